// File: doc/BRIEF.md
# Reservation Station With Tag Wakeup

This block is a small out-of-order issue buffer placed in front of a single functional unit. Dispatch writes one operation per cycle into a free slot. The operation carries an opcode and two source operands. Each operand arrives either as a finished value or as the tag of the operation that will produce it. When no slot is free, the station raises a full indication and dispatch must hold back.

While an operation waits, every operand that is still pending is compared each cycle with the tags on several result broadcast buses. On a match, the entry takes that bus's value. A broadcast that arrives in the same cycle as a dispatch is also seen by the incoming operation. An entry with both operands present is ready. Each cycle a select stage offers the oldest ready entry to the functional unit. The offer is accepted through a valid/ready handshake, and the accepted slot is freed at the same clock edge.

Top module: `rs_station`

## Requirements
- R1: A synchronous active-high reset empties every slot: after it, `full_o` and `issue_valid_o` are both 0.
- R2: The station holds exactly `N_ENT` operations (default 4). `full_o` is 0 while fewer are held and becomes 1 in the cycle after the slot that fills it is accepted.
- R3: A dispatch made while `full_o` is 1 is dropped. It is never issued, and the slot count does not change.
- R4: An operation whose two operands are both given as values (`disp_*_rdy_i` = 1) is offered on the issue port in the cycle after its dispatch edge, with its opcode and both values.
- R5: An operand given as a tag (`disp_*_rdy_i` = 0, tag on `disp_*_tag_i`) keeps the entry from issuing until a bus carries that tag with its valid bit at 1. The bus value then replaces the tag, and the entry is offered in the next cycle.
- R6: Any of the broadcast buses can wake an operand. The two operands of one entry can be captured from different buses in the same cycle. Bus k uses tag bits [k*TAG_W +: TAG_W] and data bits [k*DATA_W +: DATA_W].
- R7: When a bus carries a matching tag in the same cycle as a dispatch, the incoming operand is stored as that bus's value, not as a pending tag.
- R8: When several entries are ready, the entry dispatched earliest is offered first, whatever slot it sits in.
- R9: While `issue_valid_o` is 1 and `issue_ready_i` is 0, the offer stays up. An accepted issue frees the slot at the same edge, so `full_o` drops in the next cycle.
- R10: A bus whose tag does not match, or whose valid bit is 0, leaves a pending operand pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | OP_W | Opcode of the dispatched operation |
| disp_a_rdy_i | input | 1 | First operand is a value (1) or a tag (0) |
| disp_a_i | input | DATA_W | First operand value |
| disp_a_tag_i | input | TAG_W | First operand producer tag |
| disp_b_rdy_i | input | 1 | Second operand is a value (1) or a tag (0) |
| disp_b_i | input | DATA_W | Second operand value |
| disp_b_tag_i | input | TAG_W | Second operand producer tag |
| bus_valid_i | input | N_BUS | Broadcast valid, one bit per bus |
| bus_tag_i | input | N_BUS*TAG_W | Broadcast tags, packed per bus |
| bus_data_i | input | N_BUS*DATA_W | Broadcast values, packed per bus |
| full_o | output | 1 | No free slot; dispatch is not accepted |
| issue_ready_i | input | 1 | Functional unit accepts the offer |
| issue_valid_o | output | 1 | An entry is offered for issue |
| issue_op_o | output | OP_W | Opcode of the offered entry |
| issue_a_o | output | DATA_W | First operand of the offered entry |
| issue_b_o | output | DATA_W | Second operand of the offered entry |

## Verification
On every cycle, the assertions check four things: at most one slot is granted, and only a ready one; the number of occupied slots moves exactly by accepted dispatches minus accepted issues; a stalled offer stays up; and reset leaves the station empty with no offer. Operand values captured from the buses, drops while full, same-cycle capture at dispatch, and oldest-first order when a younger entry sits in a lower slot are shown only by the directed scenarios, which compare issued opcodes and operands with expected values.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int RS_DEF_ENTRIES = 4;
    localparam int RS_DEF_BUSES   = 2;
    localparam int RS_DEF_DATA_W  = 16;
    localparam int RS_DEF_TAG_W   = 4;
    localparam int RS_DEF_OP_W    = 4;
endpackage

// File: rtl/rs_operand_capture.sv
module rs_operand_capture #(
    parameter int N_BUS  = 2,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic                    have_v,
    input  logic [DATA_W-1:0]       field,
    input  logic [N_BUS-1:0]        bus_valid,
    input  logic [N_BUS*TAG_W-1:0]  bus_tag,
    input  logic [N_BUS*DATA_W-1:0] bus_data,
    output logic                    nxt_v,
    output logic [DATA_W-1:0]       nxt_field
);
    // A pending operand keeps its producer tag in the low bits of the field.
    always_comb begin
        nxt_v     = have_v;
        nxt_field = field;
        if (!have_v) begin
            // Scan from the top so that the lowest matching bus wins.
            for (int k = N_BUS - 1; k >= 0; k--) begin
                if (bus_valid[k] && (bus_tag[k*TAG_W +: TAG_W] == field[TAG_W-1:0])) begin
                    nxt_v     = 1'b1;
                    nxt_field = bus_data[k*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_ENT-1:0] busy,
    output logic [IDX_W-1:0] idx,
    output logic             any_free
);
    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx      = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N_ENT = 4
) (
    input  logic [N_ENT-1:0]       ready,
    input  logic [N_ENT*N_ENT-1:0] older,
    output logic [N_ENT-1:0]       grant
);
    // older[i*N_ENT + j] set: entry i was dispatched before entry j.
    for (genvar i = 0; i < N_ENT; i++) begin : g_row
        always_comb begin
            grant[i] = ready[i];
            for (int j = 0; j < N_ENT; j++) begin
                if (!((j == i) || !ready[j] || older[i*N_ENT + j])) begin
                    grant[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int N_ENT  = RS_DEF_ENTRIES,
    parameter int N_BUS  = RS_DEF_BUSES,
    parameter int DATA_W = RS_DEF_DATA_W,
    parameter int TAG_W  = RS_DEF_TAG_W,
    parameter int OP_W   = RS_DEF_OP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    disp_valid_i,
    input  logic [OP_W-1:0]         disp_op_i,
    input  logic                    disp_a_rdy_i,
    input  logic [DATA_W-1:0]       disp_a_i,
    input  logic [TAG_W-1:0]        disp_a_tag_i,
    input  logic                    disp_b_rdy_i,
    input  logic [DATA_W-1:0]       disp_b_i,
    input  logic [TAG_W-1:0]        disp_b_tag_i,
    input  logic [N_BUS-1:0]        bus_valid_i,
    input  logic [N_BUS*TAG_W-1:0]  bus_tag_i,
    input  logic [N_BUS*DATA_W-1:0] bus_data_i,
    output logic                    full_o,
    input  logic                    issue_ready_i,
    output logic                    issue_valid_o,
    output logic [OP_W-1:0]         issue_op_o,
    output logic [DATA_W-1:0]       issue_a_o,
    output logic [DATA_W-1:0]       issue_b_o
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic              busy;
        logic [OP_W-1:0]   op;
        logic              a_v;
        logic [DATA_W-1:0] a;
        logic              b_v;
        logic [DATA_W-1:0] b;
    } entry_t;

    typedef struct packed {
        entry_t [N_ENT-1:0]            ent;
        logic [N_ENT-1:0][N_ENT-1:0]   older;
    } state_t;

    state_t st_d, st_q;

    logic [N_ENT-1:0]       busy_vec, ready_vec, grant_vec;
    logic [N_ENT*N_ENT-1:0] older_flat;
    logic [IDX_W-1:0]       alloc_idx;
    logic                   any_free, accept, fire;

    logic [N_ENT-1:0]             cap_a_v, cap_b_v;
    logic [N_ENT-1:0][DATA_W-1:0] cap_a, cap_b;
    logic                         dcap_a_v, dcap_b_v;
    logic [DATA_W-1:0]            dcap_a, dcap_b;

    // Occupancy, wakeup condition and age matrix views of the state.
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign busy_vec[i]  = st_q.ent[i].busy;
        assign ready_vec[i] = st_q.ent[i].busy & st_q.ent[i].a_v & st_q.ent[i].b_v;
        for (genvar j = 0; j < N_ENT; j++) begin : g_col
            assign older_flat[i*N_ENT + j] = st_q.older[i][j];
        end

        rs_operand_capture #(.N_BUS(N_BUS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_a (
            .have_v    (st_q.ent[i].a_v),
            .field     (st_q.ent[i].a),
            .bus_valid (bus_valid_i),
            .bus_tag   (bus_tag_i),
            .bus_data  (bus_data_i),
            .nxt_v     (cap_a_v[i]),
            .nxt_field (cap_a[i])
        );

        rs_operand_capture #(.N_BUS(N_BUS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_b (
            .have_v    (st_q.ent[i].b_v),
            .field     (st_q.ent[i].b),
            .bus_valid (bus_valid_i),
            .bus_tag   (bus_tag_i),
            .bus_data  (bus_data_i),
            .nxt_v     (cap_b_v[i]),
            .nxt_field (cap_b[i])
        );
    end

    // Incoming operands see the buses of the dispatch cycle.
    rs_operand_capture #(.N_BUS(N_BUS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dcap_a (
        .have_v    (disp_a_rdy_i),
        .field     (disp_a_rdy_i ? disp_a_i : DATA_W'(disp_a_tag_i)),
        .bus_valid (bus_valid_i),
        .bus_tag   (bus_tag_i),
        .bus_data  (bus_data_i),
        .nxt_v     (dcap_a_v),
        .nxt_field (dcap_a)
    );

    rs_operand_capture #(.N_BUS(N_BUS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dcap_b (
        .have_v    (disp_b_rdy_i),
        .field     (disp_b_rdy_i ? disp_b_i : DATA_W'(disp_b_tag_i)),
        .bus_valid (bus_valid_i),
        .bus_tag   (bus_tag_i),
        .bus_data  (bus_data_i),
        .nxt_v     (dcap_b_v),
        .nxt_field (dcap_b)
    );

    rs_free_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_free (
        .busy     (busy_vec),
        .idx      (alloc_idx),
        .any_free (any_free)
    );

    rs_age_pick #(.N_ENT(N_ENT)) u_sel (
        .ready (ready_vec),
        .older (older_flat),
        .grant (grant_vec)
    );

    assign full_o        = ~any_free;
    assign accept        = disp_valid_i & any_free;
    assign issue_valid_o = |grant_vec;
    assign fire          = issue_valid_o & issue_ready_i;

    // Issue mux: the grant is one-hot, so an OR of masked fields suffices.
    always_comb begin
        issue_op_o = '0;
        issue_a_o  = '0;
        issue_b_o  = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant_vec[i]) begin
                issue_op_o = issue_op_o | st_q.ent[i].op;
                issue_a_o  = issue_a_o  | st_q.ent[i].a;
                issue_b_o  = issue_b_o  | st_q.ent[i].b;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        // Wakeup of waiting operands.
        for (int i = 0; i < N_ENT; i++) begin
            st_d.ent[i].a_v = cap_a_v[i];
            st_d.ent[i].a   = cap_a[i];
            st_d.ent[i].b_v = cap_b_v[i];
            st_d.ent[i].b   = cap_b[i];
        end
        // Deallocation of the accepted entry.
        if (fire) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (grant_vec[i]) begin
                    st_d.ent[i].busy = 1'b0;
                end
            end
        end
        // Allocation into the lowest free slot; the new entry is youngest.
        if (accept) begin
            st_d.ent[alloc_idx].busy = 1'b1;
            st_d.ent[alloc_idx].op   = disp_op_i;
            st_d.ent[alloc_idx].a_v  = dcap_a_v;
            st_d.ent[alloc_idx].a    = dcap_a;
            st_d.ent[alloc_idx].b_v  = dcap_b_v;
            st_d.ent[alloc_idx].b    = dcap_b;
            for (int j = 0; j < N_ENT; j++) begin
                st_d.older[alloc_idx][j] = 1'b0;
                st_d.older[j][alloc_idx] = (j != int'(alloc_idx));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int N_ENT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid_i,
    input logic             full_o,
    input logic             issue_valid_o,
    input logic             issue_ready_i,
    input logic [N_ENT-1:0] busy_vec,
    input logic [N_ENT-1:0] ready_vec,
    input logic [N_ENT-1:0] grant_vec
);
    int occ, occ_plus, occ_minus;
    assign occ       = $countones(busy_vec);
    assign occ_plus  = (disp_valid_i && !full_o) ? 1 : 0;
    assign occ_minus = (issue_valid_o && issue_ready_i) ? 1 : 0;

    // R1
    reset_empty_chk: assert property (@(posedge clk) rst |=> (!issue_valid_o && !full_o));

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_vec));

    // R8
    grant_ready_chk: assert property (@(posedge clk) disable iff (rst) ((grant_vec & ~ready_vec) == '0));

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (occ == $past(occ) + $past(occ_plus) - $past(occ_minus)));

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && !issue_ready_i) |=> issue_valid_o);
endmodule

bind rs_station rs_station_chk #(.N_ENT(N_ENT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .disp_valid_i  (disp_valid_i),
    .full_o        (full_o),
    .issue_valid_o (issue_valid_o),
    .issue_ready_i (issue_ready_i),
    .busy_vec      (busy_vec),
    .ready_vec     (ready_vec),
    .grant_vec     (grant_vec)
);

// File: tb/sim_rs_station.sv
`timescale 1ns/1ps
module sim_rs_station;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid_i = 1'b0;
    logic [3:0]  disp_op_i = '0;
    logic        disp_a_rdy_i = 1'b0, disp_b_rdy_i = 1'b0;
    logic [15:0] disp_a_i = '0, disp_b_i = '0;
    logic [3:0]  disp_a_tag_i = '0, disp_b_tag_i = '0;
    logic [1:0]  bus_valid_i = '0;
    logic [7:0]  bus_tag_i = '0;
    logic [31:0] bus_data_i = '0;
    logic        issue_ready_i = 1'b0;
    logic        full_o, issue_valid_o;
    logic [3:0]  issue_op_o;
    logic [15:0] issue_a_o, issue_b_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rs_station u0 (
        .clk(clk), .rst(rst),
        .disp_valid_i(disp_valid_i), .disp_op_i(disp_op_i),
        .disp_a_rdy_i(disp_a_rdy_i), .disp_a_i(disp_a_i), .disp_a_tag_i(disp_a_tag_i),
        .disp_b_rdy_i(disp_b_rdy_i), .disp_b_i(disp_b_i), .disp_b_tag_i(disp_b_tag_i),
        .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
        .full_o(full_o), .issue_ready_i(issue_ready_i), .issue_valid_o(issue_valid_o),
        .issue_op_o(issue_op_o), .issue_a_o(issue_a_o), .issue_b_o(issue_b_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_bus(int k, logic [3:0] t, logic [15:0] d);
        bus_valid_i[k]          = 1'b1;
        bus_tag_i[k*4 +: 4]     = t;
        bus_data_i[k*16 +: 16]  = d;
    endtask

    task automatic clr_bus();
        bus_valid_i = '0;
        bus_tag_i   = '0;
        bus_data_i  = '0;
    endtask

    // One dispatch cycle; any bus already driven is seen in the same cycle.
    task automatic disp(logic [3:0] op, logic ar, logic [15:0] a, logic [3:0] at,
                        logic br, logic [15:0] b, logic [3:0] bt);
        disp_valid_i = 1'b1;
        disp_op_i    = op;
        disp_a_rdy_i = ar; disp_a_i = a; disp_a_tag_i = at;
        disp_b_rdy_i = br; disp_b_i = b; disp_b_tag_i = bt;
        tick();
        disp_valid_i = 1'b0;
    endtask

    task automatic expect_issue(string req, logic [3:0] op, logic [15:0] a, logic [15:0] b);
        chk(req, "issue_valid", issue_valid_o, 1);
        chk(req, "issue_op", issue_op_o, op);
        chk(req, "issue_a", issue_a_o, a);
        chk(req, "issue_b", issue_b_o, b);
        issue_ready_i = 1'b1;
        tick();
        issue_ready_i = 1'b0;
    endtask

    task automatic expect_none(string req);
        chk(req, "issue_valid idle", issue_valid_o, 0);
    endtask

    task automatic t_reset();
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1", "full after reset", full_o, 0);
        expect_none("R1");
        disp(4'h9, 1, 16'h0001, 0, 1, 16'h0002, 0);
        chk("R1", "pre-reset offer", issue_valid_o, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        expect_none("R1");
        chk("R1", "full after mid reset", full_o, 0);
    endtask

    task automatic t_value();
        disp(4'h1, 1, 16'h0011, 0, 1, 16'h0022, 0);
        chk("R4", "ready next cycle", issue_valid_o, 1);
        tick();
        chk("R9", "hold valid", issue_valid_o, 1);
        chk("R9", "hold op", issue_op_o, 4'h1);
        tick();
        expect_issue("R4", 4'h1, 16'h0011, 16'h0022);
        expect_none("R9");
    endtask

    task automatic t_tag();
        disp(4'h2, 0, 16'h0000, 4'h3, 1, 16'h0055, 0);
        expect_none("R5");
        tick();
        expect_none("R5");
        set_bus(0, 4'h5, 16'h0099);
        tick();
        clr_bus();
        expect_none("R10");
        bus_tag_i[3:0] = 4'h3;
        bus_data_i[15:0] = 16'h0666;
        tick();
        clr_bus();
        expect_none("R10");
        set_bus(0, 4'h3, 16'hAAAA);
        tick();
        clr_bus();
        expect_issue("R5", 4'h2, 16'hAAAA, 16'h0055);
    endtask

    task automatic t_multibus();
        disp(4'h3, 0, 16'h0000, 4'h6, 0, 16'h0000, 4'h7);
        expect_none("R6");
        set_bus(1, 4'h6, 16'h1234);
        set_bus(0, 4'h7, 16'h4321);
        tick();
        clr_bus();
        expect_issue("R6", 4'h3, 16'h1234, 16'h4321);
    endtask

    task automatic t_same_cycle();
        set_bus(0, 4'h9, 16'hBEEF);
        disp(4'h4, 0, 16'h0000, 4'h9, 1, 16'h0001, 0);
        clr_bus();
        expect_issue("R7", 4'h4, 16'hBEEF, 16'h0001);
        expect_none("R7");
    endtask

    task automatic t_full_order();
        for (int i = 0; i < 4; i++) begin
            disp(4'(i), 0, 16'h0000, 4'(i + 1), 1, 16'(16'h0010 + i), 0);
            chk("R2", "full while filling", full_o, (i == 3) ? 1 : 0);
        end
        disp(4'hF, 1, 16'hFFFF, 0, 1, 16'hFFFF, 0);
        chk("R3", "full kept after drop", full_o, 1);
        expect_none("R3");
        set_bus(0, 4'h1, 16'h0100);
        tick();
        clr_bus();
        expect_issue("R5", 4'h0, 16'h0100, 16'h0010);
        chk("R9", "full drops after issue", full_o, 0);
        // Wake an older entry in slot 2 as a new entry enters slot 0.
        set_bus(0, 4'h3, 16'h0300);
        disp(4'h8, 1, 16'h0800, 0, 1, 16'h0801, 0);
        clr_bus();
        expect_issue("R8", 4'h2, 16'h0300, 16'h0012);
        expect_issue("R8", 4'h8, 16'h0800, 16'h0801);
        set_bus(0, 4'h2, 16'h0200);
        set_bus(1, 4'h4, 16'h0400);
        tick();
        clr_bus();
        expect_issue("R8", 4'h1, 16'h0200, 16'h0011);
        expect_issue("R6", 4'h3, 16'h0400, 16'h0013);
        expect_none("R3");
        chk("R2", "empty after drain", full_o, 0);
    endtask

    initial begin
        t_reset();
        t_value();
        t_tag();
        t_multibus();
        t_same_cycle();
        t_full_order();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule